// File: doc/BRIEF.md
# Host Link Loader and Command Dispatcher

This block is the front end between a byte-wide serial link and an image codec that shares a single external byte-wide SRAM. After reset it treats every byte from the receiver as file data. It writes each byte to the lower half of the SRAM, at consecutive addresses starting from zero. The link has no framing and no checksum. The only end-of-file marker is a silence on the receive side that lasts a set number of clock cycles. The silence timer is armed by the first byte only, so any idle time before the file starts does not count.

Once the silence has been seen, the block never returns to loading until the next reset, and each received byte is treated as a one-byte command. Byte `EEh` sends a single-cycle start pulse to the processing engine. The block then waits for the engine's done signal and keeps the last output address the engine reports. Byte `AAh` reads the upper half of the SRAM from its first address up to that stored address, inclusive, and hands each byte to the transmitter with a valid/ready handshake. Any other byte is dropped. A byte that arrives while a command is still running is also dropped.

The SRAM read data is taken combinationally in the same cycle as the address. While the engine is running, the block drives no write strobe, so the engine owns the memory.

Top module: `host_link_ctrl`

## Requirements
- R1: After reset the block is loading, and `tx_valid`, `eng_start` and `mem_we` are low.
- R2: While loading, a byte with `rx_valid` high raises `mem_we` in the same cycle. `mem_wdata` equals the byte, and `mem_addr` is 0 for the first byte and one higher for each byte after it.
- R3: Loading writes only to the lower half of the address space. That region is addresses 0 to 2^(ADDR_W-1)-1. Once its top address is filled, further file bytes leave `mem_we` low and the upper half unchanged.
- R4: A byte that follows the previous byte after GAP_CYCLES-1 idle cycles is still file data. After GAP_CYCLES idle cycles, loading ends and later bytes are never written.
- R5: Idle cycles before the first file byte do not end loading.
- R6: In command mode, byte `EEh` drives `eng_start` high for exactly the one cycle that follows the byte.
- R7: When `eng_done` is high during a run, `eng_last_addr` is stored as the inclusive end of later `AAh` transfers. Before any run, the end is the first upper-half address, 2^(ADDR_W-1).
- R8: In command mode, byte `AAh` sends, in address order, the SRAM bytes from 2^(ADDR_W-1) to the stored end. Each byte is presented on `tx_byte` with `tx_valid` high and is held unchanged until a cycle in which `tx_ready` is high.
- R9: Bytes other than `AAh` and `EEh` are ignored in command mode. Any byte received while a run or a transfer is still in progress is also ignored.
- R10: `mem_we` is never high outside loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | 8 | SRAM write data |
| mem_we | output | 1 | SRAM write strobe |
| mem_rdata | input | 8 | SRAM read data for the current address |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_done | input | 1 | Engine has finished |
| eng_last_addr | input | ADDR_W | Last output address written by the engine |

## Verification
The assertions assume that `eng_done` comes only after a start pulse. They also assume that the engine reports a last address that is not below the first upper-half address. Finally, they assume that the transmitter may hold `tx_ready` low for any number of cycles.

The bench models the engine itself. It raises done only during a run and reports an address inside the upper half. It toggles `tx_ready` so that both stalled and immediate acceptance occur. All inputs change on the falling edge, so each byte is held for exactly one rising edge.

// File: rtl/host_link_ctrl.sv
module host_link_ctrl #(
  parameter int ADDR_W     = 19,
  parameter int GAP_CYCLES = 1_000_000,
  parameter logic [7:0] CMD_SEND = 8'hAA,
  parameter logic [7:0] CMD_RUN  = 8'hEE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic [ADDR_W-1:0] eng_last_addr
);
  localparam logic [ADDR_W-1:0] IN_TOP   = {1'b0, {(ADDR_W-1){1'b1}}};
  localparam logic [ADDR_W-1:0] OUT_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam int CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

  typedef enum logic [2:0] {S_LOAD, S_CMD, S_RUN, S_RD, S_TX} state_t;

  state_t            st;
  logic [ADDR_W-1:0] wptr, rptr, end_addr;
  logic [CNT_W-1:0]  gap;
  logic              full, seen, start_q;
  logic [7:0]        txd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_LOAD;
      wptr     <= '0;
      rptr     <= OUT_BASE;
      end_addr <= OUT_BASE;
      gap      <= '0;
      full     <= 1'b0;
      seen     <= 1'b0;
      start_q  <= 1'b0;
      txd      <= '0;
    end else begin
      start_q <= 1'b0;
      case (st)
        S_LOAD: begin
          if (rx_valid) begin
            seen <= 1'b1;
            gap  <= '0;
            if (!full) begin
              wptr <= wptr + 1'b1;
              if (wptr == IN_TOP) full <= 1'b1;
            end
          end else if (seen) begin
            if (gap == GAP_LAST) st <= S_CMD;
            else                 gap <= gap + 1'b1;
          end
        end
        S_CMD: begin
          if (rx_valid && rx_byte == CMD_RUN) begin
            start_q <= 1'b1;
            st      <= S_RUN;
          end else if (rx_valid && rx_byte == CMD_SEND) begin
            rptr <= OUT_BASE;
            st   <= S_RD;
          end
        end
        S_RUN: begin
          if (eng_done) begin
            end_addr <= eng_last_addr;
            st       <= S_CMD;
          end
        end
        S_RD: begin
          txd <= mem_rdata;
          st  <= S_TX;
        end
        S_TX: begin
          if (tx_ready) begin
            if (rptr == end_addr) begin
              st <= S_CMD;
            end else begin
              rptr <= rptr + 1'b1;
              st   <= S_RD;
            end
          end
        end
        default: st <= S_LOAD;
      endcase
    end
  end

  assign mem_we    = (st == S_LOAD) && rx_valid && !full;
  assign mem_addr  = (st == S_LOAD) ? wptr : rptr;
  assign mem_wdata = rx_byte;
  assign tx_valid  = (st == S_TX);
  assign tx_byte   = txd;
  assign eng_start = start_q;
endmodule

module host_link_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_byte,
  input logic              eng_start
);
  localparam logic [ADDR_W-1:0] IN_TOP = {1'b0, {(ADDR_W-1){1'b1}}};

  AST_WRITE_IN_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr <= IN_TOP); // R3
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R6
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R8
  AST_TX_READS_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> mem_addr > IN_TOP); // R8
  AST_NO_WRITE_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || eng_start) |-> !mem_we); // R10
endmodule

bind host_link_ctrl host_link_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_host_link_ctrl.sv
`timescale 1ns/1ps
module test_host_link_ctrl;
  localparam int AW  = 8;
  localparam int GAP = 20;
  localparam logic [AW-1:0] OUT0 = 8'h80;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, tx_ready = 0, eng_done = 0;
  logic [7:0] rx_byte = 0;
  logic [AW-1:0] eng_last_addr = 0;
  logic tx_valid, mem_we, eng_start;
  logic [7:0] tx_byte, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem [256];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  host_link_ctrl #(.ADDR_W(AW), .GAP_CYCLES(GAP)) i_host_link_ctrl (
    .clk, .rst_n, .rx_valid, .rx_byte, .tx_valid, .tx_byte, .tx_ready,
    .mem_addr, .mem_wdata, .mem_we, .mem_rdata, .eng_start, .eng_done,
    .eng_last_addr);

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) mem[k] <= (k >= 128) ? 8'(8'h40 + k) : 8'h00;
    end else if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  localparam logic [7:0] FILE_V [8] = '{8'h12, 8'hAA, 8'hEE, 8'h00, 8'hFF, 8'h5A, 8'h81, 8'h3C};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b; #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); rx_valid = 0; end
    #1;
  endtask

  task automatic collect(input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      while (!tx_valid && w < 50) begin @(negedge clk); #1; w++; end
      chk("R8 tx byte", tx_byte, 8'(8'hC0 + i));
      if (stall) begin
        @(negedge clk); #1;
        chk("R8 held valid", tx_valid, 1);
        chk("R8 held byte", tx_byte, 8'(8'hC0 + i));
      end
      @(negedge clk); tx_ready = 1;
      @(negedge clk); tx_ready = 0; #1;
    end
    idle(6);
    chk("R8 inclusive end, no extra byte", tx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 eng_start", eng_start, 0);
    chk("R1 mem_we", mem_we, 0);
    @(negedge clk); rst_n = 1;
    idle(GAP + 10);
    for (int i = 0; i < 8; i++) begin
      put(FILE_V[i]);
      chk("R5/R2 we", mem_we, 1);
      chk("R2 addr", mem_addr, i);
      chk("R2 data", mem_wdata, FILE_V[i]);
      idle(1 + i);
    end
    for (int i = 0; i < 8; i++) chk("R2 stored", mem[i], FILE_V[i]);
    idle(GAP - 1 - 8);
    put(8'h77);
    chk("R4 gap-1 still data", mem_we, 1);
    chk("R4 gap-1 addr", mem_addr, 8);
    idle(GAP);
    put(8'h55);
    chk("R4 after gap no write", mem_we, 0);
    idle(4);
    chk("R9 unknown byte ignored", tx_valid | eng_start, 0);
    chk("R4 addr 9 untouched", mem[9], 0);
    put(8'hAA); idle(1);
    collect(1, 1);
    put(8'hEE); idle(1);
    chk("R6 start pulse", eng_start, 1);
    idle(1);
    chk("R6 start drops", eng_start, 0);
    put(8'hAA); put(8'hEE); idle(4);
    chk("R9 bytes during run ignored", tx_valid | eng_start, 0);
    @(negedge clk); eng_last_addr = OUT0 + 3; eng_done = 1;
    @(negedge clk); eng_done = 0;
    idle(2);
    put(8'hAA); idle(1);
    for (int i = 0; i < 2; i++) begin
      int w = 0;
      while (!tx_valid && w < 50) begin @(negedge clk); #1; w++; end
      chk("R7 tx byte", tx_byte, 8'(8'hC0 + i));
      if (i == 0) begin put(8'hEE); idle(2); chk("R9 cmd during send ignored", eng_start, 0); end
      @(negedge clk); tx_ready = 1;
      @(negedge clk); tx_ready = 0; #1;
    end
    collect_rest();
    chk("R10 no writes in command mode", mem_we, 0);
    // R3 overflow phase
    @(negedge clk); rst_n = 0; idle(2); @(negedge clk); rst_n = 1;
    for (int i = 0; i < 130; i++) begin
      put(8'(i + 1));
      chk("R3 write limited to low half", mem_we, (i < 128) ? 1 : 0);
    end
    idle(2);
    chk("R3 top of low half", mem[127], 8'd128);
    chk("R3 high half untouched", mem[128], 8'hC0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic collect_rest();
    for (int i = 2; i < 4; i++) begin
      int w = 0;
      while (!tx_valid && w < 50) begin @(negedge clk); #1; w++; end
      chk("R7 stored end bound", tx_byte, 8'(8'hC0 + i));
      @(negedge clk); tx_ready = 1;
      @(negedge clk); tx_ready = 0; #1;
    end
    idle(6);
    chk("R7 stops at reported address", tx_valid, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule